// File: doc/BRIEF.md
# Reloading Prescaled Capture Timer

This block is one time base for a capture/compare array. It holds a 16-bit up-counter that advances by one on every count enable. When the counter stands at FFFFh and an enable arrives, it does not wrap to zero. It loads a software-written reload value and raises an overflow request for one clock. The live count goes straight to the neighbouring compare and capture logic. A capture/compare array normally uses two independent copies of this block.

The count enable comes from one of three sources, chosen by a select field:
- a prescaler of the system clock, dividing by 8·2^n;
- a single-cycle overflow/underflow pulse from another timer;
- rising edges on an external count pin, which pass through a two-flop synchronizer.

The reload value sets the period. With reload R the period is (65536 − R) steps of the chosen source, so a reload of 0000h gives 65536 steps.

A small control state machine gates all counting. It has two states:
- `ST_HALT`: the counter is stopped and the prescaler is held at zero.
- `ST_RUN`: the counter advances on each enable.

The state machine takes the transition *start* (`ST_HALT`→`ST_RUN`) when the run input is sampled high. It takes the transition *stop* (`ST_RUN`→`ST_HALT`) when the run input is sampled low. A software write to the count register overrides counting in the cycle it happens.

Top module: `cc_timebase`

## Requirements
- R1: After reset the count is 0000h, the reload register is 0000h, overflow is low and the state machine is in `ST_HALT`.
- R2: With source select 0, the counter advances once every 8·2^n clock cycles, where n is the 3-bit prescale select.
- R3: With source select 1, the counter advances once for every clock cycle in which the external overflow input is high.
- R4: With source select 2, the counter advances once per rising edge of the count pin. That edge is seen through a two-flop synchronizer and an edge register, so the count changes at the third clock edge after the pin rises. Holding the pin high gives only one step.
- R5: Source select 3 selects no source, and the count does not change.
- R6: When the count is FFFFh and an enable arrives, the same clock edge loads the reload value and raises overflow for one cycle. The overflow period is (65536 − reload) steps.
- R7: While the run input is low the count holds. After run is sampled high in the prescaler mode, the first step lands 8·2^n clock edges after the *start* transition.
- R8: A count-register write loads the written value at the next edge, even when an enable is present in that cycle.
- R9: A reload-register write leaves the count untouched. The new value is used at the next overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run control; high enables counting |
| src_sel_i | input | 2 | Count source: 0 prescaler, 1 external overflow, 2 count pin, 3 none |
| presc_sel_i | input | 3 | Prescale exponent n; divide by 8·2^n |
| ext_ovf_i | input | 1 | Overflow/underflow pulse from another timer |
| cnt_pin_i | input | 1 | Asynchronous external count pin |
| cnt_wr_i | input | 1 | Count-register write strobe |
| cnt_wdata_i | input | 16 | Count-register write data |
| rel_wr_i | input | 1 | Reload-register write strobe |
| rel_wdata_i | input | 16 | Reload-register write data |
| count_o | output | 16 | Live timer value |
| reload_o | output | 16 | Current reload value |
| ovf_o | output | 1 | Overflow request, one cycle per reload |

## Verification
Each result has a fixed latency, and the bench samples every output at a falling edge placed on that latency:
- A count write or an external-overflow step shows one edge after the input.
- A run change acts through the state register, so it adds one edge.
- A prescaler step lands 8·2^n edges after the *start* transition.
- A pin step lands three edges after the pin rises.

Overflow periods are measured as the number of falling edges between two overflow pulses. They are compared with (65536 − reload) times the step length, which the bench computes from the source and its setting.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        SRC_PRESC = 2'd0,
        SRC_EXT   = 2'd1,
        SRC_PIN   = 2'd2,
        SRC_OFF   = 2'd3
    } src_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int DIV_W = BASE_LOG2 + NSEL - 1;

    logic [DIV_W-1:0] div_q;
    logic [NSEL-1:0]  hit;

    // a tap hits when its low BASE_LOG2+g bits are all ones
    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_tap
            assign hit[g] = &div_q[BASE_LOG2+g-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     div_q <= '0;
        else if (clr_i) div_q <= '0;
        else            div_q <= div_q + 1'b1;
    end

    assign tick_o = hit[sel_i] && !clr_i;

    // R2: a tick is always followed by a cleared tap region
    assert_tick_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (div_q[BASE_LOG2-1:0] == '0));
endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

    // R4: one rising edge yields exactly one enable cycle
    assert_single_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             rel_wr_i,
    input  logic [CNT_W-1:0] rel_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q, reload_q;
    logic             ovf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else if (wr_i) begin
            count_q <= wdata_i;
            ovf_q   <= 1'b0;
        end else if (en_i && count_q == MAXV) begin
            count_q <= reload_q;
            ovf_q   <= 1'b1;
        end else if (en_i) begin
            count_q <= count_q + 1'b1;
            ovf_q   <= 1'b0;
        end else begin
            ovf_q   <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        reload_q <= '0;
        else if (rel_wr_i) reload_q <= rel_wdata_i;
    end

    assign count_o  = count_q;
    assign reload_o = reload_q;
    assign ovf_o    = ovf_q;

    assert_reload_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (count_q == $past(reload_q)));
    assert_wrap_from_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> ($past(count_q) == MAXV));
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (count_q == $past(wdata_i)));
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !wr_i && count_q != MAXV) |=> (count_q == CNT_W'($past(count_q) + 1'b1)));
endmodule

// File: rtl/cc_timebase.sv
module cc_timebase #(
    parameter int CNT_W     = 16,
    parameter int PSEL_W    = 3,
    parameter int BASE_LOG2 = 3,
    parameter int SYNC_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [1:0]        src_sel_i,
    input  logic [PSEL_W-1:0] presc_sel_i,
    input  logic              ext_ovf_i,
    input  logic              cnt_pin_i,
    input  logic              cnt_wr_i,
    input  logic [CNT_W-1:0]  cnt_wdata_i,
    input  logic              rel_wr_i,
    input  logic [CNT_W-1:0]  rel_wdata_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              ovf_o
);
    import tmr_pkg::*;

    run_state_e state_q, state_d;
    src_e       src;
    logic       presc_clr, presc_tick, pin_rise, src_en, cnt_en;

    assign src = src_e'(src_sel_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // next state: start / stop transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_i)  state_d = ST_RUN;
            ST_RUN:  if (!run_i) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // source selection
    always_comb begin
        unique case (src)
            SRC_PRESC: src_en = presc_tick;
            SRC_EXT:   src_en = ext_ovf_i;
            SRC_PIN:   src_en = pin_rise;
            SRC_OFF:   src_en = 1'b0;
            default:   src_en = 1'b0;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        cnt_en    = 1'b0;
        presc_clr = 1'b1;
        unique case (state_q)
            ST_HALT: begin
                cnt_en    = 1'b0;
                presc_clr = 1'b1;
            end
            ST_RUN: begin
                cnt_en    = src_en;
                presc_clr = (src != SRC_PRESC);
            end
            default: ;
        endcase
    end

    tmr_prescaler #(.SEL_W(PSEL_W), .BASE_LOG2(BASE_LOG2)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (presc_clr),
        .sel_i  (presc_sel_i),
        .tick_o (presc_tick)
    );

    tmr_pin_edge #(.STAGES(SYNC_LEN)) u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cnt_pin_i),
        .rise_o (pin_rise)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (cnt_en),
        .wr_i        (cnt_wr_i),
        .wdata_i     (cnt_wdata_i),
        .rel_wr_i    (rel_wr_i),
        .rel_wdata_i (rel_wdata_i),
        .count_o     (count_o),
        .reload_o    (reload_o),
        .ovf_o       (ovf_o)
    );

    assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !cnt_wr_i) |=> $stable(count_o));
    assert_off_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_i == 2'd3 && !cnt_wr_i) |=> $stable(count_o));
    assert_no_ovf_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !cnt_wr_i) |=> !ovf_o);
endmodule

// File: tb/tb_cc_timebase.sv
module tb_cc_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic [1:0]  src_sel_i = 2'd0;
    logic [2:0]  presc_sel_i = 3'd0;
    logic        ext_ovf_i = 1'b0;
    logic        cnt_pin_i = 1'b0;
    logic        cnt_wr_i = 1'b0;
    logic [15:0] cnt_wdata_i = 16'd0;
    logic        rel_wr_i = 1'b0;
    logic [15:0] rel_wdata_i = 16'd0;
    logic [15:0] count_o, reload_o;
    logic        ovf_o;

    int errors = 0;
    int checks = 0;
    bit gen_on = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cc_timebase dut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .src_sel_i(src_sel_i),
        .presc_sel_i(presc_sel_i), .ext_ovf_i(ext_ovf_i), .cnt_pin_i(cnt_pin_i),
        .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i), .rel_wr_i(rel_wr_i),
        .rel_wdata_i(rel_wdata_i), .count_o(count_o), .reload_o(reload_o), .ovf_o(ovf_o)
    );

    typedef struct packed {
        logic [1:0]  src;
        logic [2:0]  psel;
        logic [15:0] rel;
        logic [15:0] gp;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 3'd0, 16'hFFF0, 16'd0},
        '{2'd0, 3'd1, 16'hFFF0, 16'd0},
        '{2'd0, 3'd3, 16'hFFF8, 16'd0},
        '{2'd0, 3'd7, 16'hFFFC, 16'd0},
        '{2'd1, 3'd0, 16'hFFF8, 16'd5},
        '{2'd1, 3'd0, 16'hFFFE, 16'd3},
        '{2'd1, 3'd0, 16'h0000, 16'd1},
        '{2'd2, 3'd0, 16'hFFFA, 16'd4},
        '{2'd2, 3'd0, 16'hFFF8, 16'd6}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_regs(input bit wc, input logic [15:0] cv, input bit wr, input logic [15:0] rv);
        cnt_wr_i = wc; cnt_wdata_i = cv; rel_wr_i = wr; rel_wdata_i = rv;
        @(negedge clk);
        cnt_wr_i = 1'b0; rel_wr_i = 1'b0;
    endtask

    task automatic wait_ovf();
        while (ovf_o !== 1'b1) @(negedge clk);
    endtask

    function automatic int expected_period(input vec_t v);
        int step;
        if (v.src == 2'd0)      step = 8 << v.psel;
        else if (v.src == 2'd1) step = int'(v.gp);
        else                    step = 2 * int'(v.gp);
        return (65536 - int'(v.rel)) * step;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int per;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count", 32'(count_o), 32'h0);
        check("R1 reload", 32'(reload_o), 32'h0);
        check("R1 ovf", 32'(ovf_o), 32'h0);
        // R1: halted after reset, count holds
        cyc(5);
        check("R1 halted", 32'(count_o), 32'h0);

        // R8 write priority with an enable present, then R3 step
        src_sel_i = 2'd1; ext_ovf_i = 1'b1; run_i = 1'b1;
        cyc(2);
        wr_regs(1'b1, 16'h1234, 1'b0, 16'h0);
        check("R8 write wins", 32'(count_o), 32'h1234);
        @(negedge clk);
        check("R3 step", 32'(count_o), 32'h1235);

        // R7 halt
        run_i = 1'b0;
        cyc(2);
        v = count_o;
        cyc(20);
        check("R7 halt holds", 32'(count_o), 32'(v));

        // R6 overflow reload
        wr_regs(1'b1, 16'hFFFF, 1'b1, 16'h00AB);
        ext_ovf_i = 1'b0; run_i = 1'b1;
        @(negedge clk);
        ext_ovf_i = 1'b1;
        @(negedge clk);
        check("R6 reload loaded", 32'(count_o), 32'h00AB);
        check("R6 ovf raised", 32'(ovf_o), 32'h1);
        ext_ovf_i = 1'b0;
        @(negedge clk);
        check("R6 ovf one cycle", 32'(ovf_o), 32'h0);

        // R5 no source
        src_sel_i = 2'd3; ext_ovf_i = 1'b1;
        cyc(2);
        v = count_o;
        cyc(20);
        check("R5 off source", 32'(count_o), 32'(v));

        // R4 pin latency and level hold
        src_sel_i = 2'd2; ext_ovf_i = 1'b0; cnt_pin_i = 1'b0;
        cyc(5);
        v = count_o;
        cnt_pin_i = 1'b1;
        cyc(2);
        check("R4 before latency", 32'(count_o), 32'(v));
        @(negedge clk);
        check("R4 third edge", 32'(count_o), 32'(16'(v + 1)));
        cyc(10);
        check("R4 level holds", 32'(count_o), 32'(16'(v + 1)));

        // R7/R2 first prescaler step after start
        run_i = 1'b0; cnt_pin_i = 1'b0; src_sel_i = 2'd0; presc_sel_i = 3'd0;
        cyc(3);
        v = count_o;
        run_i = 1'b1;
        cyc(8);
        check("R7 start no step yet", 32'(count_o), 32'(v));
        @(negedge clk);
        check("R7 first step", 32'(count_o), 32'(16'(v + 1)));

        // R9 reload write does not touch count, applies at next overflow
        run_i = 1'b0; src_sel_i = 2'd1; ext_ovf_i = 1'b0;
        cyc(2);
        wr_regs(1'b1, 16'hFFFE, 1'b1, 16'h0010);
        wr_regs(1'b0, 16'h0, 1'b1, 16'h0020);
        check("R9 count untouched", 32'(count_o), 32'hFFFE);
        check("R9 reload value", 32'(reload_o), 32'h0020);
        run_i = 1'b1; ext_ovf_i = 1'b1;
        wait_ovf();
        check("R9 new reload used", 32'(count_o), 32'h0020);
        run_i = 1'b0; ext_ovf_i = 1'b0;
        cyc(3);

        // period table: R2 (prescaler), R3 (external), R4 (pin), R6 (period)
        for (int k = 0; k < NVEC; k++) begin
            wr_regs(1'b1, 16'hFFFF, 1'b1, VECS[k].rel);
            src_sel_i = VECS[k].src;
            presc_sel_i = VECS[k].psel;
            run_i = 1'b1;
            gen_on = 1'b1;
            if (VECS[k].src == 2'd1) begin
                fork
                    begin
                        while (gen_on) begin
                            ext_ovf_i = 1'b1;
                            @(negedge clk);
                            if (VECS[k].gp > 1) begin
                                ext_ovf_i = 1'b0;
                                cyc(int'(VECS[k].gp) - 1);
                            end
                        end
                        ext_ovf_i = 1'b0;
                    end
                join_none
            end else if (VECS[k].src == 2'd2) begin
                fork
                    begin
                        while (gen_on) begin
                            cnt_pin_i = ~cnt_pin_i;
                            cyc(int'(VECS[k].gp));
                        end
                        cnt_pin_i = 1'b0;
                    end
                join_none
            end
            wait_ovf();
            per = 0;
            do begin
                @(negedge clk);
                per++;
            end while (ovf_o !== 1'b1);
            check($sformatf("R6 period vec%0d src%0d", k, VECS[k].src),
                  32'(per), 32'(expected_period(VECS[k])));
            gen_on = 1'b0;
            run_i = 1'b0;
            cyc(20);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule